// File: doc/BRIEF.md
# Load-Linked Reservation Defer Guard

This block sits next to one private cache and holds a single reservation on one cache line. A load-linked operation arms the reservation and starts a long countdown; an ordinary load that arrives while nothing is held arms it with a shorter countdown. For as long as the reservation stands, snooped bus requests from other agents that hit the reserved line are told to wait through a stall output. Snoops to any other line pass with no added delay. The bet is that the store-conditional will arrive within the window. The line then changes hands once, after the lock word has been written, and is not bounced back and forth while the critical section runs.

The reservation ends in one of three ways. A store-conditional to the reserved line succeeds and releases the line. A store-conditional that misses or arrives late fails and drops the reservation. Otherwise the countdown runs out, the reservation is dropped, and the held snoops are served. A one-cycle release pulse marks the cycle in which a held reservation ends, so the bus side can replay the requests it deferred. Addresses are compared at line granularity: the low offset bits are ignored.

Top module: `llsc_defer_guard`

## Requirements
- R1: After reset no reservation is held. `snpStall`, `scPass` and `releasePulse` are all 0 until an arming event is accepted.
- R2: When `llValid` is sampled in cycle k (with `scValid` low), `snpStall` is 1 for a snoop to the same line in cycles k+1 through k+LL_WIN. In cycle k+LL_WIN+1 it is 0.
- R3: When `ldValid` is sampled in cycle k while nothing is held, the same holds with LD_WIN in place of LL_WIN. LD_WIN is strictly smaller than LL_WIN.
- R4: An ordinary load that arrives while a reservation is held is ignored. Neither the reserved line nor the remaining window changes.
- R5: `snpStall` is 0 whenever `snpValid` is 0 or the snooped line differs from the reserved line.
- R6: In the cycle after the last stall cycle of a window (expiry), `releasePulse` is 1 and `snpStall` is 0. From the next cycle on, no reservation is held, so a later store-conditional fails.
- R7: A store-conditional to the reserved line while the reservation is held and has not expired gives `scPass`=1 and `releasePulse`=1 in that same cycle. From the next cycle on, no snoop is stalled.
- R8: A store-conditional to another line, or one made while nothing is held, gives `scPass`=0. It clears any reservation, and `releasePulse` is 1 only if a reservation was held.
- R9: A load-linked while a reservation is held replaces the reserved line with the new line and restarts the full LL_WIN window.
- R10: When `scValid` and `llValid` are sampled in the same cycle, the store-conditional is handled and the load-linked is dropped.
- R11: Two addresses match when bits [ADDR_W-1:LINE_OFF] are equal. The low LINE_OFF bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| llValid | input | 1 | Local load-linked completed with exclusive ownership |
| llAddr | input | ADDR_W | Load-linked address |
| ldValid | input | 1 | Local ordinary load |
| ldAddr | input | ADDR_W | Ordinary load address |
| scValid | input | 1 | Local store-conditional attempt |
| scAddr | input | ADDR_W | Store-conditional address |
| snpValid | input | 1 | Snooped request from another agent |
| snpAddr | input | ADDR_W | Snooped request address |
| snpStall | output | 1 | Defer the current snooped request |
| scPass | output | 1 | Store-conditional in this cycle succeeds |
| releasePulse | output | 1 | A held reservation ends in this cycle |

## Verification
Directed sequences cover a lone load-linked followed by matching snoops, which separates the long window from the short window of an idle ordinary load. They also cover an ordinary load issued during a window, which should leave the window as it was. A matching, a mismatching and a late store-conditional show success apart from failure and expiry. A re-issued load-linked to a new line shows replacement and restart, and an address that differs only in its offset bits shows line-granular matching. A seeded random mix of all four event kinds over a few lines then checks the collisions that directed tests do not reach, such as same-cycle store-conditional and load-linked, and loads that land on the expiry cycle.

// File: rtl/llsc_defer_pkg.sv
package llsc_defer_pkg;

  typedef enum logic [1:0] {
    RES_IDLE   = 2'd0,
    RES_HELDLL = 2'd1,
    RES_HELDLD = 2'd2
  } resState_t;

  typedef struct packed {
    logic loadLl;
    logic loadLd;
    logic clear;
    logic dec;
  } resStrobe_t;

endpackage

// File: rtl/llsc_defer_dp.sv
module llsc_defer_dp
  import llsc_defer_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int LL_WIN   = 64,
  parameter int LD_WIN   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  resStrobe_t        strobe,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic              scHit,
  output logic              timerZero
);

  localparam int LINE_W = ADDR_W - LINE_OFF;
  localparam int TMR_W  = $clog2(LL_WIN + 1);
  localparam logic [TMR_W-1:0] LL_LOAD = TMR_W'(LL_WIN);
  localparam logic [TMR_W-1:0] LD_LOAD = TMR_W'(LD_WIN);

  logic [LINE_W-1:0] resLine;
  logic [TMR_W-1:0]  timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resLine <= '0;
    end else if (strobe.loadLl) begin
      resLine <= llAddr[ADDR_W-1:LINE_OFF];
    end else if (strobe.loadLd) begin
      resLine <= ldAddr[ADDR_W-1:LINE_OFF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadLl) begin
      timer <= LL_LOAD;
    end else if (strobe.loadLd) begin
      timer <= LD_LOAD;
    end else if (strobe.clear) begin
      timer <= '0;
    end else if (strobe.dec && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign snpHit    = (snpAddr[ADDR_W-1:LINE_OFF] == resLine);
  assign scHit     = (scAddr[ADDR_W-1:LINE_OFF] == resLine);
  assign timerZero = (timer == '0);

endmodule

// File: rtl/llsc_defer_ctl.sv
module llsc_defer_ctl
  import llsc_defer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       llValid,
  input  logic       ldValid,
  input  logic       scValid,
  input  logic       snpValid,
  input  logic       snpHit,
  input  logic       scHit,
  input  logic       timerZero,
  output resStrobe_t strobe,
  output logic       snpStall,
  output logic       scPass,
  output logic       releasePulse
);

  resState_t state, stateNext;
  logic held;
  logic expired;
  logic live;

  assign held    = (state != RES_IDLE);
  assign expired = held && timerZero;
  assign live    = held && !timerZero;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (scValid) begin
      strobe.clear = 1'b1;
      stateNext    = RES_IDLE;
    end else if (llValid) begin
      strobe.loadLl = 1'b1;
      stateNext     = RES_HELDLL;
    end else if (ldValid && !held) begin
      strobe.loadLd = 1'b1;
      stateNext     = RES_HELDLD;
    end else if (expired) begin
      strobe.clear = 1'b1;
      stateNext    = RES_IDLE;
    end else if (held) begin
      strobe.dec = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= RES_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign snpStall     = snpValid && live && snpHit;
  assign scPass       = scValid && live && scHit;
  assign releasePulse = expired || (scValid && live);

endmodule

// File: rtl/llsc_defer_guard.sv
module llsc_defer_guard
  import llsc_defer_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int LL_WIN   = 64,
  parameter int LD_WIN   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpStall,
  output logic              scPass,
  output logic              releasePulse
);

  resStrobe_t strobe;
  logic snpHit;
  logic scHit;
  logic timerZero;

  llsc_defer_dp #(
    .ADDR_W  (ADDR_W),
    .LINE_OFF(LINE_OFF),
    .LL_WIN  (LL_WIN),
    .LD_WIN  (LD_WIN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .llAddr   (llAddr),
    .ldAddr   (ldAddr),
    .scAddr   (scAddr),
    .snpAddr  (snpAddr),
    .snpHit   (snpHit),
    .scHit    (scHit),
    .timerZero(timerZero)
  );

  llsc_defer_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .llValid     (llValid),
    .ldValid     (ldValid),
    .scValid     (scValid),
    .snpValid    (snpValid),
    .snpHit      (snpHit),
    .scHit       (scHit),
    .timerZero   (timerZero),
    .strobe      (strobe),
    .snpStall    (snpStall),
    .scPass      (scPass),
    .releasePulse(releasePulse)
  );

endmodule

// File: rtl/llsc_defer_guard_chk.sv
module llsc_defer_guard_chk #(
  parameter int LL_WIN = 64,
  parameter int LD_WIN = 16
) (
  input logic clk,
  input logic rstN,
  input logic llValid,
  input logic ldValid,
  input logic scValid,
  input logic snpValid,
  input logic snpStall,
  input logic scPass,
  input logic releasePulse
);

  localparam int CNT_W = $clog2(LL_WIN + 2) + 1;

  logic [CNT_W-1:0] sinceArm;

  initial begin
    p_window_order_r3: assert (LL_WIN > LD_WIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceArm <= '0;
    end else if (llValid || ldValid) begin
      sinceArm <= '0;
    end else if (sinceArm <= CNT_W'(LL_WIN)) begin
      sinceArm <= sinceArm + 1'b1;
    end
  end

  p_stall_needs_snoop_r5: assert property (@(posedge clk) disable iff (!rstN)
    snpStall |-> snpValid);

  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    snpStall |-> (sinceArm < CNT_W'(LL_WIN)));

  p_pass_needs_sc_r7: assert property (@(posedge clk) disable iff (!rstN)
    scPass |-> (scValid && releasePulse));

  p_sc_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    scValid |=> !snpStall);

  p_release_ends_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (releasePulse && !llValid && !ldValid) |=> !snpStall);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !(snpStall || scPass || releasePulse));

endmodule

bind llsc_defer_guard llsc_defer_guard_chk #(
  .LL_WIN(LL_WIN),
  .LD_WIN(LD_WIN)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .llValid     (llValid),
  .ldValid     (ldValid),
  .scValid     (scValid),
  .snpValid    (snpValid),
  .snpStall    (snpStall),
  .scPass      (scPass),
  .releasePulse(releasePulse)
);

// File: tb/llsc_defer_guard_tb.sv
`timescale 1ns/1ps
module llsc_defer_guard_tb;

  localparam int AW  = 16;
  localparam int OFF = 4;
  localparam int LLW = 12;
  localparam int LDW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic llValid = 0, ldValid = 0, scValid = 0, snpValid = 0;
  logic [AW-1:0] llAddr = '0, ldAddr = '0, scAddr = '0, snpAddr = '0;
  logic snpStall, scPass, releasePulse;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic mArmed = 1'b0;
  logic [AW-1:0] mAddr = '0;
  int mTimer = 0;

  always #2 clk = ~clk;

  llsc_defer_guard #(.ADDR_W(AW), .LINE_OFF(OFF), .LL_WIN(LLW), .LD_WIN(LDW)) u_dut (
    .clk(clk), .rstN(rstN),
    .llValid(llValid), .llAddr(llAddr),
    .ldValid(ldValid), .ldAddr(ldAddr),
    .scValid(scValid), .scAddr(scAddr),
    .snpValid(snpValid), .snpAddr(snpAddr),
    .snpStall(snpStall), .scPass(scPass), .releasePulse(releasePulse)
  );

  function automatic logic sameLine(logic [AW-1:0] a, logic [AW-1:0] b);
    return a[AW-1:OFF] == b[AW-1:OFF];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare with model, advance model
  task automatic step(string tag, logic ll, logic [AW-1:0] la, logic ld, logic [AW-1:0] da,
                      logic sc, logic [AW-1:0] sa, logic sn, logic [AW-1:0] na);
    logic expd, live, eStall, ePass, eRel;
    @(negedge clk);
    llValid = ll; llAddr = la; ldValid = ld; ldAddr = da;
    scValid = sc; scAddr = sa; snpValid = sn; snpAddr = na;
    #1;
    expd   = mArmed && (mTimer == 0);
    live   = mArmed && (mTimer != 0);
    eStall = sn && live && sameLine(na, mAddr);
    ePass  = sc && live && sameLine(sa, mAddr);
    eRel   = expd || (sc && live);
    check({tag, " stall (R5/R11)"}, snpStall, eStall);
    check({tag, " scPass (R7/R8)"}, scPass, ePass);
    check({tag, " release (R6/R8)"}, releasePulse, eRel);
    if (sc) begin
      mArmed = 1'b0;
    end else if (ll) begin
      mArmed = 1'b1; mAddr = la; mTimer = LLW;
    end else if (ld && !mArmed) begin
      mArmed = 1'b1; mAddr = da; mTimer = LDW;
    end else if (expd) begin
      mArmed = 1'b0;
    end else if (mArmed) begin
      mTimer--;
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, '0, 0, '0, 0, '0, 0, '0);
  endtask

  // count stall cycles for snoops to addr until a release is seen
  task automatic countWindow(string tag, logic [AW-1:0] addr, int expStalls);
    int n = 0;
    bit seenRel = 0;
    for (int i = 0; i < LLW + 3 && !seenRel; i++) begin
      step(tag, 0, '0, 0, '0, 0, '0, 1, addr);
      if (snpStall) n++;
      if (releasePulse) seenRel = 1;
    end
    check({tag, " window length"}, n == expStalls, 1'b1);
    check({tag, " release seen"}, seenRel, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    #1;
    check("R1 reset stall", snpStall, 1'b0);
    check("R1 reset release", releasePulse, 1'b0);
    rstN = 1'b1;
    step("R1 post-reset sc", 0, '0, 0, '0, 1, 16'h0000, 1, 16'h0000);
    check("R1 no pass", scPass, 1'b0);

    // R2: LL window length
    step("R2 arm", 1, 16'h1230, 0, '0, 0, '0, 0, '0);
    countWindow("R2", 16'h1230, LLW);
    // R6: after expiry an SC fails
    step("R6 late sc", 0, '0, 0, '0, 1, 16'h1230, 0, '0);
    check("R6 late sc fails", scPass, 1'b0);

    // R3: ordinary load arms short window
    step("R3 arm", 0, '0, 1, 16'h4440, 0, '0, 0, '0);
    countWindow("R3", 16'h4447, LDW);

    // R4: load while held is ignored
    step("R4 arm", 1, 16'h5000, 0, '0, 0, '0, 0, '0);
    step("R4 foreign load", 0, '0, 1, 16'h6000, 0, '0, 1, 16'h6000);
    check("R4 other line not stalled", snpStall, 1'b0);
    countWindow("R4", 16'h5000, LLW - 1);

    // R7: matching SC passes, then no stall
    step("R7 arm", 1, 16'h7000, 0, '0, 0, '0, 0, '0);
    idle("R7 wait");
    step("R7 sc", 0, '0, 0, '0, 1, 16'h700f, 1, 16'h7000);
    check("R7 pass", scPass, 1'b1);
    check("R7 release", releasePulse, 1'b1);
    step("R7 after", 0, '0, 0, '0, 0, '0, 1, 16'h7000);
    check("R7 stall cleared", snpStall, 1'b0);

    // R8: mismatched SC fails and clears
    step("R8 arm", 1, 16'h8000, 0, '0, 0, '0, 0, '0);
    step("R8 sc", 0, '0, 0, '0, 1, 16'h9000, 0, '0);
    check("R8 fail", scPass, 1'b0);
    check("R8 release", releasePulse, 1'b1);
    step("R8 after", 0, '0, 0, '0, 0, '0, 1, 16'h8000);
    check("R8 stall cleared", snpStall, 1'b0);

    // R9: LL replaces and restarts
    step("R9 arm a", 1, 16'hA000, 0, '0, 0, '0, 0, '0);
    repeat (4) idle("R9 wait");
    step("R9 arm b", 1, 16'hB000, 0, '0, 0, '0, 0, '0);
    step("R9 old line", 0, '0, 0, '0, 0, '0, 1, 16'hA000);
    check("R9 old line free", snpStall, 1'b0);
    countWindow("R9", 16'hB000, LLW - 1);

    // R10: SC and LL in same cycle -> LL dropped
    step("R10 arm", 1, 16'hC000, 0, '0, 0, '0, 0, '0);
    step("R10 both", 1, 16'hD000, 0, '0, 1, 16'hC000, 0, '0);
    check("R10 sc passes", scPass, 1'b1);
    step("R10 after", 0, '0, 0, '0, 0, '0, 1, 16'hD000);
    check("R10 ll dropped", snpStall, 1'b0);

    // R11: offset bits ignored
    step("R11 arm", 1, 16'hE001, 0, '0, 0, '0, 0, '0);
    step("R11 snoop", 0, '0, 0, '0, 0, '0, 1, 16'hE00E);
    check("R11 offset match", snpStall, 1'b1);
    step("R11 neighbour", 0, '0, 0, '0, 0, '0, 1, 16'hE010);
    check("R11 next line no match", snpStall, 1'b0);

    // random mix (R2..R11 via model)
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a[4];
      for (int j = 0; j < 4; j++)
        a[j] = {12'(16 + $urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      step("RND", ($urandom_range(0, 99) < 8), a[0], ($urandom_range(0, 99) < 10), a[1],
           ($urandom_range(0, 99) < 6), a[2], ($urandom_range(0, 99) < 60), a[3]);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule